// File: doc/BRIEF.md
# Serial DAC Word Loader

This block is the digital receive side of a three-wire serial DAC input. A host holds the active-low frame select low and sends one 16-bit word on the serial data line, one bit per falling edge of the serial clock. The block shifts the bits in and keeps the last twelve as a two's-complement DAC code. A 12-bit holding latch drives the code output. The analog converter reads only that latch and never the shift register.

The block loads the latch in one of two ways. The mode is chosen by the level of the active-low load strobe when frame select falls. If the strobe is low, the latch loads by itself once the sixteenth bit has arrived. If the strobe is high, the latch waits for a falling edge of the strobe after the word is complete. The strobe mode lets several converters change output together.

All four external inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer and an edge detector. The system clock must run at least four times faster than the serial clock. Each latch load produces a one-cycle update pulse.

Top module: `dacld_top`

## Requirements
- R1: After reset, the code output is 0x000 (mid-scale) and the update pulse is low.
- R2: A frame carries 16 bits, sampled on serial clock falling edges while frame select is low. The first four bits are ignored. The last twelve form the code, most significant bit first. Codes such as 0x7FF (most positive) and 0x800 (most negative) pass through unchanged.
- R3: Only the first 16 falling edges of a frame are accepted. Further serial clock edges before frame select rises change neither the code nor the update count.
- R4: If the load strobe is low when frame select falls (auto mode), the latch loads once after the sixteenth bit, with no strobe activity needed.
- R5: If the load strobe is high when frame select falls (strobe mode), the code holds its old value after the sixteenth bit. It loads on the next strobe falling edge.
- R6: In strobe mode, a strobe falling edge that arrives before all 16 bits are in has no effect on the code.
- R7: If frame select rises before 16 bits have arrived, the partial word is discarded. The code is unchanged in either mode, and a later strobe falling edge loads nothing.
- R8: Each latch load gives exactly one update pulse of one system clock cycle. The code changes only in a cycle where that pulse is high.
- R9: A falling edge of frame select clears the bit count. A frame that follows an aborted or over-clocked frame loads its own 16-bit word correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Frame select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock; data is sampled on its falling edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Load strobe, active low; its level at frame start selects the mode |
| dac_code | output | 12 | Holding latch contents, two's complement |
| dac_upd | output | 1 | One-cycle pulse when the latch loads |

## Verification
A bit counter that is off by one shows up as a shifted code. In auto mode, it also shows up as a missing or early update pulse. Either is visible within a few system cycles of the sixteenth serial edge. A wrong captured mode, or a pending-load flag that outlives an abort or a new frame, shows up as a code change or update pulse when the strobe falls. The bench therefore compares the code and counts update pulses after every frame and after every strobe. It also checks the two's-complement extremes and the over-clocked, early-strobe and aborted frames.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
    localparam int unsigned WORD_BITS = 16;
    localparam int unsigned DAC_BITS  = 12;
    localparam int unsigned CNT_W     = $clog2(WORD_BITS + 1);
    localparam int unsigned SYNC_N    = 4;

    // pin indices into the synchronizer bank
    localparam int unsigned PIN_FRAME = 0;
    localparam int unsigned PIN_SCLK  = 1;
    localparam int unsigned PIN_LOAD  = 2;
    localparam int unsigned PIN_DATA  = 3;

    typedef logic [CNT_W-1:0]     bitcnt_t;
    typedef logic [DAC_BITS-1:0]  dac_code_t;
    typedef logic [WORD_BITS-1:0] word_t;

    typedef enum logic {
        UPD_AUTO   = 1'b0,
        UPD_STROBE = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } pin_ev_t;

    typedef struct packed {
        logic      done;
        logic      full;
        dac_code_t code;
    } word_stat_t;

    function automatic dac_code_t lower_code(input word_t w);
        return w[DAC_BITS-1:0];
    endfunction

    function automatic upd_mode_e mode_from_strobe(input logic strobe_level);
        return strobe_level ? UPD_STROBE : UPD_AUTO;
    endfunction
endpackage

// File: rtl/dacld_pin_sync.sv
module dacld_pin_sync
    import dacld_pkg::*;
#(
    parameter int unsigned N = 4,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       din,
    output pin_ev_t [N-1:0]    ev
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= IDLE[i];
                s2 <= IDLE[i];
                s3 <= IDLE[i];
            end else begin
                s1 <= din[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        always_comb begin
            ev[i].level = s2;
            ev[i].fall  = s3 & ~s2;
            ev[i].rise  = ~s3 & s2;
        end
    end
endmodule

// File: rtl/dacld_shifter.sv
module dacld_shifter
    import dacld_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_fall,
    input  logic       frame_level,
    input  logic       sclk_fall,
    input  logic       data_level,
    output bitcnt_t    bit_cnt,
    output word_stat_t stat
);
    localparam bitcnt_t LAST = bitcnt_t'(WORD_BITS);

    word_t   sreg;
    bitcnt_t cnt;
    logic    done_q;
    logic    take_bit;

    assign take_bit = sclk_fall && !frame_level && (cnt != LAST) && !frame_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_fall) begin
                cnt <= '0;
            end else if (take_bit) begin
                sreg <= {sreg[WORD_BITS-2:0], data_level};
                cnt  <= cnt + 1'b1;
                if (cnt == LAST - 1'b1) done_q <= 1'b1;
            end
        end
    end

    assign bit_cnt   = cnt;
    assign stat.done = done_q;
    assign stat.full = (cnt == LAST);
    assign stat.code = lower_code(sreg);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R9
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_fall |=> (cnt == '0));
endmodule

// File: rtl/dacld_latch.sv
module dacld_latch
    import dacld_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_fall,
    input  logic       load_level,
    input  logic       load_fall,
    input  word_stat_t stat,
    output dac_code_t  code,
    output logic       upd
);
    upd_mode_e mode;
    logic      pending;
    dac_code_t hold;
    logic      upd_q;
    logic      do_load;

    always_comb begin
        do_load = 1'b0;
        if (!frame_fall) begin
            if (mode == UPD_AUTO)
                do_load = stat.done;
            else
                do_load = load_fall && pending && stat.full;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= UPD_AUTO;
            pending <= 1'b0;
            hold    <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= do_load;
            if (do_load) hold <= stat.code;
            if (frame_fall) begin
                mode    <= mode_from_strobe(load_level);
                pending <= 1'b0;
            end else if (do_load) begin
                pending <= 1'b0;
            end else if (stat.done && mode == UPD_STROBE) begin
                pending <= 1'b1;
            end
        end
    end

    assign code = hold;
    assign upd  = upd_q;

    // R8
    one_cycle_upd_chk: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> !upd_q);
    // R8
    hold_code_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_q |-> $stable(hold));
endmodule

// File: rtl/dacld_top.sv
module dacld_top
    import dacld_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                load_n,
    output logic [DAC_BITS-1:0] dac_code,
    output logic                dac_upd
);
    localparam logic [SYNC_N-1:0] IDLE_PINS = 4'b0101;

    logic [SYNC_N-1:0] raw;
    pin_ev_t [SYNC_N-1:0] ev;
    bitcnt_t    cnt;
    word_stat_t stat;

    always_comb begin
        raw            = '0;
        raw[PIN_FRAME] = frame_n;
        raw[PIN_SCLK]  = ser_clk;
        raw[PIN_LOAD]  = load_n;
        raw[PIN_DATA]  = ser_data;
    end

    dacld_pin_sync #(.N(SYNC_N), .IDLE(IDLE_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .ev  (ev)
    );

    dacld_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .frame_fall  (ev[PIN_FRAME].fall),
        .frame_level (ev[PIN_FRAME].level),
        .sclk_fall   (ev[PIN_SCLK].fall),
        .data_level  (ev[PIN_DATA].level),
        .bit_cnt     (cnt),
        .stat        (stat)
    );

    dacld_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .frame_fall (ev[PIN_FRAME].fall),
        .load_level (ev[PIN_LOAD].level),
        .load_fall  (ev[PIN_LOAD].fall),
        .stat       (stat),
        .code       (dac_code),
        .upd        (dac_upd)
    );

    // R6
    upd_full_chk: assert property (@(posedge clk) disable iff (rst)
        dac_upd |-> (cnt == bitcnt_t'(WORD_BITS)));
endmodule

// File: tb/sim_dacld_top.sv
module sim_dacld_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0, load_n = 1'b1;
    logic [11:0] dac_code;
    logic dac_upd;
    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dacld_top u0 (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk),
        .ser_data(ser_data), .load_n(load_n), .dac_code(dac_code), .dac_upd(dac_upd)
    );

    always @(negedge clk) if (!rst && dac_upd) pulses++;

    // {strobe mode, 16-bit word}; expected code is word[11:0]
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 16'hF7FF}, {1'b1, 16'h0800}, {1'b0, 16'hA000}, {1'b1, 16'h5123},
        {1'b0, 16'h0FFF}, {1'b1, 16'h3001}, {1'b0, 16'hC555}, {1'b1, 16'h1AAA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic frame_start(input bit strobe_mode);
        load_n = strobe_mode;
        wait_clk(6);
        frame_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic frame_end();
        wait_clk(4);
        frame_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = bits[31-i];
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
    endtask

    task automatic strobe();
        load_n = 1'b0;
        wait_clk(6);
        load_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        logic [11:0] prev;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        chk("R1 code after reset", dac_code, 12'h000);
        chk("R1 no update after reset", pulses, 0);

        // table of frames in both modes
        for (int v = 0; v < 8; v++) begin
            bit sm = VEC[v][16];
            logic [15:0] w = VEC[v][15:0];
            prev = dac_code;
            p0 = pulses;
            frame_start(sm);
            send_bits({w, 16'h0}, 16);
            if (sm) begin
                chk("R5 held before strobe", dac_code, prev);
                chk("R5 no pulse before strobe", pulses - p0, 0);
                frame_end();
                strobe();
                chk("R5/R2 strobe load", dac_code, w[11:0]);
            end else begin
                chk("R4/R2 auto load", dac_code, w[11:0]);
                frame_end();
            end
            chk("R8 one pulse per load", pulses - p0, 1);
        end

        // R3: extra clocks after 16 bits ignored
        p0 = pulses;
        frame_start(1'b0);
        send_bits(32'h9234_FFFF, 24);
        frame_end();
        chk("R3 lockout code", dac_code, 12'h234);
        chk("R3 lockout pulses", pulses - p0, 1);

        // R6: early strobe ignored, later strobe loads
        p0 = pulses;
        frame_start(1'b1);
        send_bits(32'h0ABC_0000, 8);
        strobe();
        chk("R6 early strobe code", dac_code, 12'h234);
        chk("R6 early strobe pulses", pulses - p0, 0);
        send_bits(32'hBC00_0000, 8);
        frame_end();
        strobe();
        chk("R6 late strobe loads", dac_code, 12'hABC);

        // R7: aborted frame in strobe mode, then strobe
        p0 = pulses;
        frame_start(1'b1);
        send_bits(32'h0123_0000, 10);
        frame_end();
        strobe();
        chk("R7 abort strobe code", dac_code, 12'hABC);
        chk("R7 abort strobe pulses", pulses - p0, 0);

        // R7: aborted frame in auto mode
        frame_start(1'b0);
        send_bits(32'h0456_0000, 10);
        frame_end();
        chk("R7 abort auto code", dac_code, 12'hABC);
        chk("R7 abort auto pulses", pulses - p0, 0);

        // R9: fresh frame after abort loads its own word
        frame_start(1'b0);
        send_bits(32'hE801_0000, 16);
        frame_end();
        chk("R9 new frame after abort", dac_code, 12'h801);
        chk("R9 pulse count", pulses - p0, 1);

        // R1: reset mid-operation returns to mid-scale
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(3);
        chk("R1 code after second reset", dac_code, 12'h000);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule